// File: doc/BRIEF.md
# DRAM Access Controller with Refresh Arbitration

This block sits between a bus master with an asynchronous handshake and an asynchronous DRAM array. The master starts a cycle by pulling its address strobe low. It holds the address and the read/write line steady until the block answers with a data acknowledge. The block then drives the row and column strobes, the write and output enables and a multiplexed address bus. It sends the row half of the address first and the column half after it. Every control edge falls on a rising clock edge, so the smallest step between two edges is one clock period.

An internal interval timer asks for a refresh at a fixed period. Refresh uses CAS-before-RAS ordering. The master has no retry line and no way to learn that a refresh is running. When the two collide, the block withholds the acknowledge, completes the refresh and then serves the waiting access. An access that has already begun always runs to completion. After every RAS-active period the array gets at least one clock of precharge.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is held, and on the first edge after it, ras_n, cas_n, we_n, oe_n and ack_n are all high (deasserted).
- R2: If as_n is sampled low at edge k while the block is idle and no refresh is pending, then ras_n goes low after edge k+1 and ma carries the row field addr[ADDR_W-1:COL_W]. After edge k+2, ma carries the column field addr[COL_W-1:0]. cas_n goes low after edge k+3.
- R3: rw=1 means read and drives oe_n low from the CAS edge onward. rw=0 means write and drives we_n low instead. we_n and oe_n are never low together.
- R4: ack_n goes low one edge after cas_n. It stays low for as long as as_n stays low. On the edge after as_n is sampled high, ack_n, ras_n, cas_n, we_n and oe_n all go high.
- R5: Once ras_n rises, it stays high for at least one full clock.
- R6: After reset, the timer requests a refresh every REFRESH_PERIOD clocks. A request stays pending until the sequencer accepts it.
- R7: A refresh drives cas_n low one clock before ras_n. It then holds both low for one clock and releases both on the same edge. we_n, oe_n and ack_n stay high throughout.
- R8: When a pending refresh and a new request meet in the idle state, the refresh runs first. ack_n stays high until the delayed access finishes its normal sequence.
- R9: A refresh that becomes due during an access waits until that access is acknowledged and its precharge has ended.
- R10: ack_n is low only while both ras_n and cas_n are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock (one period is the edge quantum) |
| rst_n | input | 1 | Synchronous active-low reset |
| as_n | input | 1 | Address strobe from the bus master, active low |
| rw | input | 1 | 1 = read, 0 = write; valid while as_n is low |
| addr | input | ROW_W+COL_W | Word address, row field in the upper bits |
| ma | output | max(ROW_W,COL_W) | Multiplexed row/column address to the array |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| ack_n | output | 1 | Data acknowledge to the master, active low |

## Verification
The assertions assume that the master behaves as an asynchronous bus master should. It keeps as_n low, with addr and rw stable, until it has seen ack_n low. It raises as_n only after that acknowledge. The stimulus changes inputs only on falling clock edges. It lowers as_n only while the block is idle and raises it only after sampling ack_n low. Every cycle therefore follows the handshake. The bench counts clocks from reset release and places requests on, before and across the refresh due points. This is how it exercises the collision orderings.

// File: rtl/dram_ctrl_pkg.sv
// Package: shared sequencer state encoding for the DRAM controller.
// Assumes: one state register in access_sequencer, outputs decoded from it.
package dram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for request or refresh
        ST_ROW  = 3'd1,   // RAS low, row address on ma
        ST_COL  = 3'd2,   // RAS low, column address on ma
        ST_CAS  = 3'd3,   // RAS and CAS low, enable driven
        ST_ACK  = 3'd4,   // acknowledge low until strobe negated
        ST_PRE  = 3'd5,   // all strobes high, precharge
        ST_RCAS = 3'd6,   // refresh: CAS low first
        ST_RRAS = 3'd7    // refresh: CAS and RAS low
    } seq_state_t;

endpackage

// File: rtl/refresh_timer.sv
// Module: refresh_timer
// Counts clocks and raises a sticky refresh request every PERIOD clocks.
// Assumes: take is pulsed for one clock when the sequencer accepts a request.
module refresh_timer #(
    parameter int PERIOD = 156
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    output logic pending
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt;
    logic             due;

    assign due = (cnt == LAST);

    // interval counter, wraps at PERIOD
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (due) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end

    // sticky request: set on expiry, cleared on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= due | (pending & ~take);
    end

    // R6
    sticky_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !take) |=> pending);

endmodule

// File: rtl/addr_mux.sv
// Module: addr_mux
// Selects the row or column field of the word address onto the array bus.
// Assumes: row field in the upper ROW_W bits, column field in the lower COL_W.
module addr_mux #(
    parameter int ROW_W = 8,
    parameter int COL_W = 8,
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_col,
    output logic [MA_W-1:0]   ma
);
    logic [MA_W-1:0] row_f;
    logic [MA_W-1:0] col_f;

    // zero-extend the narrower field to the bus width
    generate
        if (ROW_W == MA_W) begin : g_row_full
            assign row_f = addr[ADDR_W-1:COL_W];
        end else begin : g_row_pad
            assign row_f = {{(MA_W-ROW_W){1'b0}}, addr[ADDR_W-1:COL_W]};
        end
        if (COL_W == MA_W) begin : g_col_full
            assign col_f = addr[COL_W-1:0];
        end else begin : g_col_pad
            assign col_f = {{(MA_W-COL_W){1'b0}}, addr[COL_W-1:0]};
        end
    endgenerate

    // row/column multiplexer
    always_comb begin
        ma = sel_col ? col_f : row_f;
    end

endmodule

// File: rtl/access_sequencer.sv
// Module: access_sequencer
// Arbitrates refresh against master requests and sequences the strobes.
// Assumes: master holds as_n low with stable rw until ack_n is seen low.
module access_sequencer
    import dram_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic as_n,
    input  logic rw,
    input  logic ref_pend,
    output logic ref_take,
    output logic sel_col,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic oe_n,
    output logic ack_n
);
    seq_state_t state, nxt;
    logic       rd_q;
    logic       start_acc;
    logic       in_data;

    assign ref_take  = (state == ST_IDLE) && ref_pend;
    assign start_acc = (state == ST_IDLE) && !ref_pend && !as_n;

    // next-state: refresh wins only in idle, accesses never aborted
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (ref_pend)   nxt = ST_RCAS;
                     else if (!as_n) nxt = ST_ROW;
            ST_ROW:  nxt = ST_COL;
            ST_COL:  nxt = ST_CAS;
            ST_CAS:  nxt = ST_ACK;
            ST_ACK:  if (as_n) nxt = ST_PRE;
            ST_PRE:  nxt = ST_IDLE;
            ST_RCAS: nxt = ST_RRAS;
            ST_RRAS: nxt = ST_PRE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // capture the direction when the access is accepted
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_q <= 1'b1;
        else if (start_acc) rd_q <= rw;
    end

    // strobe and enable decode from the state register
    always_comb begin
        in_data = (state == ST_CAS) || (state == ST_ACK);
        ras_n   = !((state == ST_ROW) || (state == ST_COL) || in_data ||
                    (state == ST_RRAS));
        cas_n   = !(in_data || (state == ST_RCAS) || (state == ST_RRAS));
        oe_n    = !(in_data && rd_q);
        we_n    = !(in_data && !rd_q);
        ack_n   = !(state == ST_ACK);
        sel_col = (state == ST_COL) || in_data;
    end

    // R3
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n));

    // R4
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && as_n) |=> (ack_n && ras_n && cas_n && we_n && oe_n));

    // R5
    ras_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> ras_n);

    // R7
    cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> !$past(cas_n));

    // R2
    row_before_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !ras_n) |-> (!$past(ras_n) && !$past(ras_n, 2)));

    // R8
    refresh_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ref_pend && !as_n) |=> (!cas_n && ras_n && ack_n));

    // R10
    ack_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> (!ras_n && !cas_n));

endmodule

// File: rtl/dram_refresh_ctrl.sv
// Module: dram_refresh_ctrl (top)
// DRAM controller: row/column access sequencing with CAS-before-RAS refresh.
// Assumes: synchronous inputs; refresh delays the acknowledge, never a retry.
module dram_refresh_ctrl #(
    parameter int ROW_W          = 8,
    parameter int COL_W          = 8,
    parameter int REFRESH_PERIOD = 156,
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    output logic [MA_W-1:0]   ma,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              oe_n,
    output logic              ack_n
);
    logic ref_pend;
    logic ref_take;
    logic sel_col;

    refresh_timer #(.PERIOD(REFRESH_PERIOD)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (ref_take),
        .pending (ref_pend)
    );

    access_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .as_n     (as_n),
        .rw       (rw),
        .ref_pend (ref_pend),
        .ref_take (ref_take),
        .sel_col  (sel_col),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .ack_n    (ack_n)
    );

    addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_mux (
        .addr    (addr),
        .sel_col (sel_col),
        .ma      (ma)
    );

endmodule

// File: tb/dram_refresh_ctrl_test.sv
module dram_refresh_ctrl_test;
    localparam int CLK_PERIOD = 100;
    localparam int P = 40;

    typedef struct packed {
        logic        rw;
        logic [15:0] addr;
        logic [1:0]  hold;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b1, 16'hA35C, 2'd0},
        '{1'b0, 16'h0FF0, 2'd2},
        '{1'b1, 16'h5A01, 2'd0},
        '{1'b0, 16'hC3E7, 2'd1},
        '{1'b1, 16'hFFFF, 2'd0}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic as_n = 1;
    logic rw = 1;
    logic [15:0] addr = '0;
    logic [7:0] ma;
    logic ras_n, cas_n, we_n, oe_n, ack_n;
    int errors = 0;
    int checks = 0;
    int tcount = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_refresh_ctrl #(.ROW_W(8), .COL_W(8), .REFRESH_PERIOD(P)) uut (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .rw(rw), .addr(addr),
        .ma(ma), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .ack_n(ack_n)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at t=%0d: actual=%0h expected=%0h",
                     req, what, tcount, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        tcount++;
    endtask

    task automatic wait_until(input int t);
        while (tcount < t) tick();
    endtask

    task automatic chk_idle(input string req);
        chk(req, "ras_n", 32'(ras_n), 1);
        chk(req, "cas_n", 32'(cas_n), 1);
        chk(req, "we_n",  32'(we_n),  1);
        chk(req, "oe_n",  32'(oe_n),  1);
        chk(req, "ack_n", 32'(ack_n), 1);
    endtask

    // pre = 4: a refresh runs before the access row phase
    task automatic run_access(input logic r, input logic [15:0] a,
                              input int hold, input int pre);
        as_n = 0; rw = r; addr = a;
        for (int i = 0; i < pre; i++) begin
            tick();
            chk("R8", "ack_n held off", 32'(ack_n), 1);
            chk("R7", "we_n in refresh", 32'(we_n), 1);
            chk("R7", "oe_n in refresh", 32'(oe_n), 1);
            chk("R7", "cas_n refresh", 32'(cas_n), (i < 2) ? 0 : 1);
            chk("R7", "ras_n refresh", 32'(ras_n), (i == 1) ? 0 : 1);
        end
        tick();
        chk("R2", "ras_n row", 32'(ras_n), 0);
        chk("R2", "ma row", 32'(ma), 32'(a[15:8]));
        chk("R2", "cas_n row", 32'(cas_n), 1);
        tick();
        chk("R2", "ma col", 32'(ma), 32'(a[7:0]));
        chk("R2", "cas_n col", 32'(cas_n), 1);
        tick();
        chk("R2", "cas_n low", 32'(cas_n), 0);
        chk("R3", "oe_n", 32'(oe_n), r ? 0 : 1);
        chk("R3", "we_n", 32'(we_n), r ? 1 : 0);
        chk("R4", "ack_n before", 32'(ack_n), 1);
        tick();
        chk("R4", "ack_n low", 32'(ack_n), 0);
        chk("R10", "strobes under ack", 32'({ras_n, cas_n}), 0);
        for (int h = 0; h < hold; h++) begin
            tick();
            chk("R4", "ack_n held", 32'(ack_n), 0);
        end
        as_n = 1;
        tick();
        chk_idle("R4");
        tick();
        chk("R5", "ras_n precharge", 32'(ras_n), 1);
        chk("R5", "cas_n precharge", 32'(cas_n), 1);
    endtask

    initial begin
        repeat (4) tick();
        chk_idle("R1");
        rst_n = 1;
        tcount = 0;
        tick();
        chk_idle("R1");

        // first refresh with no master activity (R6, R7)
        wait_until(P);
        chk("R6", "cas_n before due", 32'(cas_n), 1);
        tick();
        chk("R7", "cas_n first", 32'(cas_n), 0);
        chk("R7", "ras_n after cas", 32'(ras_n), 1);
        tick();
        chk("R7", "both low", 32'({ras_n, cas_n}), 0);
        chk("R7", "ack_n in refresh", 32'(ack_n), 1);
        tick();
        chk("R7", "both released", 32'({ras_n, cas_n}), 3);

        // table walk within one refresh window
        wait_until(P + 4);
        for (int v = 0; v < 5; v++)
            run_access(VECS[v].rw, VECS[v].addr, int'(VECS[v].hold), 0);

        // collision: request and due refresh meet in idle (R8)
        wait_until(2 * P);
        run_access(1'b1, 16'h3C96, 0, 4);

        // refresh becomes due mid-access (R9)
        wait_until(3 * P - 2);
        run_access(1'b0, 16'h7E18, 0, 0);
        tick();
        chk("R9", "deferred refresh cas_n", 32'(cas_n), 0);
        chk("R9", "deferred refresh ras_n", 32'(ras_n), 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule